// File: doc/BRIEF.md
# Single-Channel Prescaled PWM Timer

This block produces one pulse-width-modulated output from a free-running counter. The counter sits behind a power-of-two prescaler. A small synchronous register port configures the block. Software sets the division code and the output polarity while the timer is disabled. It then enables the timer, loads a reload value and a compare value, and starts the counter. The counter then runs continuously from 0 up to the reload value and wraps.

The reload and compare values that software writes go into holding registers. The counter copies them into its working copies at start and at every wrap, so the waveform never changes mid-period. After each accepted write, a per-register "write-ok" status flag rises with a fixed latency. The flag stays set until software writes a 1 to the matching bit of the flag-clear register.

Register map (3-bit address):

| Address | Register | Contents |
|---|---|---|
| 0 | control | bit0 enable, bit1 start/running |
| 1 | config | bits[2:0] prescaler code, bit3 polarity |
| 2 | reload | reload value |
| 3 | compare | compare value |
| 4 | status | bit0 compare-ok, bit1 reload-ok |
| 5 | flag-clear | write-only, reads 0 |
| 6, 7 | unused | read 0 |

Reads are combinational from `reg_addr`.

Top module: `lp_pwm_timer`

## Requirements
- R1: After reset, every readable register reads 0 and `pwm_out` is 0.
- R2: The enable bit reads back at control bit0, and the running state at bit1. The prescaler code (config bits[2:0]) and polarity (config bit3) read back as written. Reload and compare read back exactly as written.
- R3: A config write while enable is 1 is ignored, and config keeps its previous value.
- R4: A reload or compare write while enable is 0 is ignored: the register keeps its value and sets no status flag.
- R5: An accepted write sets its status flag (reload-ok at status bit1, compare-ok at status bit0) on the second clock edge counted from the edge that accepts the write. Writing 1 to flag-clear bit1 clears reload-ok, and writing 1 to bit0 clears compare-ok. A 0 bit has no effect.
- R6: With prescaler code p and reload R, the counter steps once every 2^p clocks and wraps from R to 0, so the output period is (R+1)·2^p clocks.
- R7: The output is active while the counter is greater than the working compare value C. Each period therefore has (R − min(C,R))·2^p active clocks.
- R8: Polarity 0 gives an active-high output and polarity 1 gives an active-low output.
- R9: While the counter is not running, `pwm_out` equals the polarity bit (the inactive level). Writing 0 to control stops the counter and clears enable.
- R10: The counter starts only when control is written with both bit0 and bit1 set. A start bit written without enable leaves the timer disabled and stopped.
- R11: A reload or compare write while running has no effect on the waveform until the next counter wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for `reg_addr` (combinational) |
| pwm_out | output | 1 | PWM output |

## Verification
The bench sweeps prescaler codes 0 to 2, reload values 1 to 5, and every compare value from 0 to one past reload. It checks the active-clock count and the periodicity of each waveform. A design with an off-by-one wrap or prescaler fails the periodicity check. One that compares with `>=` or mishandles a compare above reload gets the high count wrong.

The enable-state gates are probed with writes at the wrong time, followed by read-back. A missing gate shows up as a changed register or a spurious flag. The flag latency is checked on both edges that follow the write, so a flag raised one cycle early or late fails.

A compare change in mid-period confirms that the working copy waits for the wrap. A design that updates at once would raise the output before the old threshold.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam logic [2:0] ADR_CTRL   = 3'd0;
  localparam logic [2:0] ADR_CFG    = 3'd1;
  localparam logic [2:0] ADR_RELOAD = 3'd2;
  localparam logic [2:0] ADR_CMP    = 3'd3;
  localparam logic [2:0] ADR_STAT   = 3'd4;
  localparam logic [2:0] ADR_CLR    = 3'd5;

  localparam int BIT_EN    = 0;
  localparam int BIT_START = 1;
  localparam int BIT_CMPOK = 0;
  localparam int BIT_RLDOK = 1;
endpackage

// File: rtl/lpt_regs.sv
module lpt_regs #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [2:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             en_o,
  output logic             run_o,
  output logic             start_o,
  output logic [PSC_W-1:0] psc_o,
  output logic             pol_o,
  output logic [CNT_W-1:0] rld_sh_o,
  output logic [CNT_W-1:0] cmp_sh_o,
  output logic             rld_ok_o,
  output logic             cmp_ok_o
);
  import lpt_pkg::*;

  logic en_q, run_q, pol_q, rld_pend, cmp_pend, rld_ok_q, cmp_ok_q;
  logic [PSC_W-1:0] psc_q;
  logic [CNT_W-1:0] rld_q, cmp_q;
  logic wr_ctrl, wr_cfg, wr_rld, wr_cmp, clr_rld, clr_cmp;

  assign wr_ctrl = wr && (addr == ADR_CTRL);
  assign wr_cfg  = wr && (addr == ADR_CFG) && !en_q;
  assign wr_rld  = wr && (addr == ADR_RELOAD) && en_q;
  assign wr_cmp  = wr && (addr == ADR_CMP) && en_q;
  assign clr_rld = wr && (addr == ADR_CLR) && wdata[BIT_RLDOK];
  assign clr_cmp = wr && (addr == ADR_CLR) && wdata[BIT_CMPOK];
  assign start_o = wr_ctrl && wdata[BIT_EN] && wdata[BIT_START] && !run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      run_q <= 1'b0;
      psc_q <= '0;
      pol_q <= 1'b0;
      rld_q <= '0;
      cmp_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= wdata[BIT_EN];
        run_q <= wdata[BIT_EN] & (wdata[BIT_START] | run_q);
      end
      if (wr_cfg) begin
        psc_q <= wdata[PSC_W-1:0];
        pol_q <= wdata[PSC_W];
      end
      if (wr_rld) rld_q <= wdata;
      if (wr_cmp) cmp_q <= wdata;
    end
  end

  // two-stage write-ok pipeline: accept edge, then flag edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rld_pend <= 1'b0;
      cmp_pend <= 1'b0;
      rld_ok_q <= 1'b0;
      cmp_ok_q <= 1'b0;
    end else begin
      rld_pend <= wr_rld;
      cmp_pend <= wr_cmp;
      rld_ok_q <= rld_pend | (rld_ok_q & ~clr_rld);
      cmp_ok_q <= cmp_pend | (cmp_ok_q & ~clr_cmp);
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADR_CTRL: begin
        rdata[BIT_EN]    = en_q;
        rdata[BIT_START] = run_q;
      end
      ADR_CFG: begin
        rdata[PSC_W-1:0] = psc_q;
        rdata[PSC_W]     = pol_q;
      end
      ADR_RELOAD: rdata = rld_q;
      ADR_CMP:    rdata = cmp_q;
      ADR_STAT: begin
        rdata[BIT_CMPOK] = cmp_ok_q;
        rdata[BIT_RLDOK] = rld_ok_q;
      end
      default: rdata = '0;
    endcase
  end

  assign en_o     = en_q;
  assign run_o    = run_q;
  assign psc_o    = psc_q;
  assign pol_o    = pol_q;
  assign rld_sh_o = rld_q;
  assign cmp_sh_o = cmp_q;
  assign rld_ok_o = rld_ok_q;
  assign cmp_ok_o = cmp_ok_q;
endmodule

// File: rtl/lpt_prescaler.sv
module lpt_prescaler #(
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] code,
  output logic             tick
);
  localparam int DIV_W = (2 ** PSC_W) - 1;

  logic [DIV_W-1:0] div_q, limit;

  // limit = 2^code - 1, a run of code ones
  assign limit = ~({DIV_W{1'b1}} << code);
  assign tick  = run && (div_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) div_q <= '0;
    else if (tick)      div_q <= '0;
    else                div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/lpt_counter.sv
module lpt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             start,
  input  logic             tick,
  input  logic [CNT_W-1:0] rld_sh,
  input  logic [CNT_W-1:0] cmp_sh,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] rld_act_o,
  output logic             active_o
);
  logic [CNT_W-1:0] cnt_q, rld_act, cmp_act;
  logic wrap;

  assign wrap = tick && (cnt_q == rld_act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      rld_act <= '0;
      cmp_act <= '0;
    end else if (start) begin
      cnt_q   <= '0;
      rld_act <= rld_sh;
      cmp_act <= cmp_sh;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (wrap) begin
      cnt_q   <= '0;
      rld_act <= rld_sh;
      cmp_act <= cmp_sh;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign active_o  = run && (cnt_q > cmp_act);
  assign cnt_o     = cnt_q;
  assign rld_act_o = rld_act;
endmodule

// File: rtl/lp_pwm_timer.sv
module lp_pwm_timer #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             pwm_out
);
  logic en_q, run_q, start_p, pol_q, rld_ok, cmp_ok, tick, active;
  logic [PSC_W-1:0] psc_q;
  logic [CNT_W-1:0] rld_sh, cmp_sh, cnt, rld_act;

  lpt_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .en_o(en_q), .run_o(run_q), .start_o(start_p),
    .psc_o(psc_q), .pol_o(pol_q), .rld_sh_o(rld_sh), .cmp_sh_o(cmp_sh),
    .rld_ok_o(rld_ok), .cmp_ok_o(cmp_ok)
  );

  lpt_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(run_q), .code(psc_q), .tick(tick)
  );

  lpt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run_q), .start(start_p), .tick(tick),
    .rld_sh(rld_sh), .cmp_sh(cmp_sh), .cnt_o(cnt), .rld_act_o(rld_act),
    .active_o(active)
  );

  assign pwm_out = active ^ pol_q;
endmodule

// File: rtl/lp_pwm_timer_checker.sv
module lp_pwm_timer_checker #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [2:0]       reg_addr,
  input logic             en,
  input logic             run,
  input logic             tick,
  input logic [PSC_W-1:0] psc,
  input logic             pol,
  input logic [CNT_W-1:0] rld_sh,
  input logic [CNT_W-1:0] cmp_sh,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] rld_act,
  input logic             rld_ok,
  input logic             pwm_out
);
  logic rld_hit;
  assign rld_hit = reg_wr && (reg_addr == lpt_pkg::ADR_RELOAD) && en;

  p_cfg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> $stable({psc, pol}));
  p_shadow_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable({rld_sh, cmp_sh}));
  p_flag_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rld_hit |-> ##2 rld_ok);
  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == rld_act) |=> (cnt == '0));
  p_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= rld_act);
  p_idle_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (pwm_out == pol));
endmodule

bind lp_pwm_timer lp_pwm_timer_checker #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .en(en_q),
  .run(run_q), .tick(tick), .psc(psc_q), .pol(pol_q), .rld_sh(rld_sh),
  .cmp_sh(cmp_sh), .cnt(cnt), .rld_act(rld_act), .rld_ok(rld_ok),
  .pwm_out(pwm_out)
);

// File: tb/lp_pwm_timer_tb.sv
module lp_pwm_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_CTRL = 3'd0, A_CFG = 3'd1, A_RLD = 3'd2,
                         A_CMP = 3'd3, A_STAT = 3'd4, A_CLR = 3'd5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic pwm_out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic samp [0:1023];

  always #(CLK_PERIOD/2) clk = ~clk;

  lp_pwm_timer u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic setup(input int p, input int pol, input int r, input int c);
    wr(A_CTRL, 16'd0);
    wr(A_CFG, 16'((pol << 3) | p));
    wr(A_CTRL, 16'd1);
    wr(A_RLD, 16'(r));
    wr(A_CMP, 16'(c));
    wr(A_CTRL, 16'd3);
  endtask

  // settle, then capture 2P samples; report active count and periodicity
  task automatic measure(input int per, output int hi, output int periodic);
    repeat (2 * per + 3) @(negedge clk);
    for (int i = 0; i < 2 * per; i++) begin
      @(negedge clk);
      samp[i] = pwm_out;
    end
    hi = 0; periodic = 1;
    for (int i = 0; i < per; i++) begin
      if (samp[i]) hi++;
      if (samp[i] != samp[i + per]) periodic = 0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog all requirements: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int hi, per_ok, per, exp_hi, allok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk("R1", $sformatf("reg %0d after reset", a), int'(d), 0);
    end
    chk("R1", "pwm_out after reset", int'(pwm_out), 0);

    // R2 readback while disabled
    wr(A_CFG, 16'hD);
    rd(A_CFG, d); chk("R2", "config readback", int'(d), 13);
    wr(A_CTRL, 16'd1);
    rd(A_CTRL, d); chk("R2", "control readback enabled", int'(d), 1);
    wr(A_RLD, 16'hA5C3);
    rd(A_RLD, d); chk("R2", "reload readback", int'(d), 16'hA5C3);
    wr(A_CMP, 16'h1234);
    rd(A_CMP, d); chk("R2", "compare readback", int'(d), 16'h1234);

    // R3 config locked while enabled
    wr(A_CFG, 16'h2);
    rd(A_CFG, d); chk("R3", "config write while enabled ignored", int'(d), 13);

    // R10 enabled but not started: inactive (pol=1 -> 1)
    allok = 1;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (pwm_out !== 1'b1) allok = 0; end
    chk("R10", "enabled not started holds inactive", allok, 1);

    // R4 writes while disabled ignored, no flags
    wr(A_CLR, 16'd3);
    wr(A_CTRL, 16'd0);
    wr(A_CLR, 16'd3);
    wr(A_RLD, 16'd77);
    wr(A_CMP, 16'd55);
    repeat (3) @(negedge clk);
    rd(A_RLD, d);  chk("R4", "reload write while disabled ignored", int'(d), 16'hA5C3);
    rd(A_CMP, d);  chk("R4", "compare write while disabled ignored", int'(d), 16'h1234);
    rd(A_STAT, d); chk("R4", "no flag from ignored writes", int'(d), 0);

    // R10 start without enable
    wr(A_CTRL, 16'd2);
    rd(A_CTRL, d); chk("R10", "start without enable ignored", int'(d), 0);
    allok = 1;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (pwm_out !== 1'b1) allok = 0; end
    chk("R10", "output inactive after lone start", allok, 1);

    // R5 flag latency and clearing
    wr(A_CTRL, 16'd1);
    wr(A_RLD, 16'd9);
    reg_addr = A_STAT; #1;
    chk("R5", "reload-ok one edge after write", int'(reg_rdata), 0);
    @(negedge clk); reg_addr = A_STAT; #1;
    chk("R5", "reload-ok two edges after write", int'(reg_rdata), 2);
    wr(A_CMP, 16'd4);
    reg_addr = A_STAT; #1;
    chk("R5", "compare-ok one edge after write", int'(reg_rdata), 2);
    @(negedge clk); reg_addr = A_STAT; #1;
    chk("R5", "both flags set", int'(reg_rdata), 3);
    wr(A_CLR, 16'd0);
    rd(A_STAT, d); chk("R5", "clear with zero bits no effect", int'(d), 3);
    wr(A_CLR, 16'd1);
    rd(A_STAT, d); chk("R5", "clear bit0 only", int'(d), 2);
    wr(A_CLR, 16'd2);
    rd(A_STAT, d); chk("R5", "clear bit1", int'(d), 0);

    // R6 R7 R8 sweep
    for (int p = 0; p < 3; p++)
      for (int r = 1; r <= 5; r++)
        for (int c = 0; c <= r + 1; c++)
          for (int pol = 0; pol < 2; pol++) begin
            if (pol == 1 && p != 1) continue;
            setup(p, pol, r, c);
            per = (r + 1) << p;
            exp_hi = (r - ((c < r) ? c : r)) << p;
            measure(per, hi, per_ok);
            chk("R6", $sformatf("period p=%0d r=%0d c=%0d", p, r, c), per_ok, 1);
            if (pol == 0)
              chk("R7", $sformatf("active clocks p=%0d r=%0d c=%0d", p, r, c), hi, exp_hi);
            else
              chk("R8", $sformatf("inverted clocks p=%0d r=%0d c=%0d", p, r, c), hi, per - exp_hi);
          end

    // R9 stop returns output to inactive level (pol=1)
    setup(0, 1, 5, 1);
    repeat (10) @(negedge clk);
    wr(A_CTRL, 16'd0);
    rd(A_CTRL, d); chk("R9", "control reads 0 after stop", int'(d), 0);
    allok = 1;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (pwm_out !== 1'b1) allok = 0; end
    chk("R9", "stopped output at inactive level", allok, 1);

    // R11 compare change waits for wrap
    setup(0, 0, 200, 100);
    wr(A_CMP, 16'd10);
    allok = 1;
    for (int i = 0; i < 60; i++) begin @(negedge clk); if (pwm_out !== 1'b0) allok = 0; end
    chk("R11", "old compare kept until wrap", allok, 1);
    measure(201, hi, per_ok);
    chk("R11", "new compare after wrap", hi, 190);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule